// File: doc/BRIEF.md
# Token-Passing Transmit Sequencer

This block runs the transmit side of one station on a token-passing network. The host first stores a packet in a local byte buffer. It then presents the destination station number, the payload length and the buffer start address together with an enable pulse. From that point the attempt is pending. The transmitter-available status drops and the delivered status clears.

When the token arrives with an attempt pending, the sequencer sends a free-buffer enquiry to the destination and waits for a decoded reply. An ACK starts the data frame on the byte stream, one byte per cycle. The frame is the destination number, a length byte, the payload read from the buffer and a CRC-16 trailer. A NAK, or silence for a bounded number of cycles, makes the sequencer pass the token instead, and the attempt stays pending for the next token.

After the data frame, an ACK from the destination marks the packet as delivered. If no ACK arrives in time, the attempt still finishes but is not marked as delivered. Either way the transmitter-available status returns and the token is passed. An interrupt output combines the status bits with a host mask. A station holding the token with nothing armed passes it on at once. A disable pulse withdraws a pending attempt the next time the token arrives.

Top module: `tpx_seq_top`

## Requirements
- R1: After reset, st_avail is 1, st_delivered is 0, and req_valid and tx_valid are 0.
- R2: A tx_enable pulse while nothing is pending arms an attempt with dest_in, len_in and base_in, and clears st_avail and st_delivered on the following cycle.
- R3: A token_in pulse while armed produces, one cycle later, a single-cycle request with req_kind 1 (free-buffer enquiry) and req_dst equal to the stored destination. No data byte is sent before the reply.
- R4: An rx_ack while the enquiry is outstanding starts the byte stream on the next cycle, one byte per cycle with tx_valid high. The order is: destination, length, then len payload bytes read from buffer addresses base, base+1, and so on, wrapping modulo the buffer size.
- R5: Two CRC bytes, low byte first, follow the payload, and tx_last is high with the final byte. The CRC uses polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant 0xA001), with initial value 0. It covers the destination, length and payload bytes.
- R6: An rx_nak, or no reply for REPLY_TMO cycles, while the enquiry is outstanding sends no data. It produces a token request (req_kind 0) to next_id and leaves the attempt pending with st_avail 0. The next token repeats the enquiry.
- R7: An rx_ack within REPLY_TMO cycles after the last data byte sets st_delivered and st_avail on the next cycle and passes the token to next_id.
- R8: With no reply within REPLY_TMO cycles after the last data byte, st_avail is set, st_delivered stays 0, and the token is passed to next_id.
- R9: A token_in pulse with nothing armed produces, one cycle later, a single-cycle token request (req_kind 0) to next_id.
- R10: irq is high exactly when (st_avail and irq_mask bit 0) or (st_delivered and irq_mask bit 1).
- R11: A tx_disable pulse while an attempt is pending cancels it at the next token. No enquiry is sent, the token goes to next_id, st_avail returns to 1 and st_delivered stays 0.
- R12: A tx_enable pulse while an attempt is pending is ignored. The stored destination is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Arm-transmit command pulse |
| tx_disable | input | 1 | Cancel-transmit command pulse |
| dest_in | input | 8 | Destination station number, sampled with tx_enable |
| len_in | input | 8 | Payload length in bytes, sampled with tx_enable |
| base_in | input | ADDR_W | Buffer address of the first payload byte, sampled with tx_enable |
| next_id | input | 8 | Station that receives the passed token |
| token_in | input | 1 | Token received pulse |
| rx_ack | input | 1 | Decoded ACK reply pulse |
| rx_nak | input | 1 | Decoded NAK reply pulse |
| irq_mask | input | 2 | Bit 0 enables st_avail, bit 1 enables st_delivered |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 8 | Buffer read data for buf_addr, same cycle |
| req_valid | output | 1 | Frame request strobe |
| req_kind | output | 1 | 0 token pass, 1 free-buffer enquiry |
| req_dst | output | 8 | Destination of the requested frame |
| tx_valid | output | 1 | Data byte valid |
| tx_byte | output | 8 | Data byte |
| tx_last | output | 1 | Final byte of the data frame |
| st_avail | output | 1 | Transmitter available status |
| st_delivered | output | 1 | Packet delivered status |
| irq | output | 1 | Masked interrupt |

## Verification
Requests and status changes appear one cycle after the edge that samples the input pulse causing them. The first data byte follows one cycle after the edge that takes the enquiry ACK, and each later byte follows one cycle after the one before it. A reply timeout takes effect REPLY_TMO edges after the edge that entered the wait. The bench drives every pulse for exactly one edge on the falling clock. It samples outputs on the falling edge right after the active edge where the change is due. For timeouts it counts edges until the token request appears and compares the count with REPLY_TMO.

// File: rtl/tpx_pkg.sv
package tpx_pkg;

    localparam int BYTE_W = 8;
    localparam logic [15:0] CRC_REFL_POLY = 16'hA001;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WENQ = 2'd1,
        S_SEND = 2'd2,
        S_WACK = 2'd3
    } seq_state_e;

    typedef enum logic {
        REQ_TOKEN = 1'b0,
        REQ_ENQ   = 1'b1
    } req_kind_e;

    typedef struct packed {
        logic delivered;
        logic avail;
    } status_t;

    typedef struct packed {
        byte_t dest;
        byte_t len;
    } job_t;

    function automatic logic [15:0] crc16_step(logic [15:0] c, byte_t b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < BYTE_W; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_REFL_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/tpx_crc16.sv
module tpx_crc16
    import tpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        step,
    input  byte_t       din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= 16'h0000;
        end else if (step) begin
            crc <= crc16_step(crc, din);
        end
    end
endmodule

// File: rtl/tpx_reply_timer.sv
module tpx_reply_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6 / R8: a wait never outlasts its window
    p_wait_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < CNT_W'(LIMIT)));
endmodule

// File: rtl/tpx_frame_gen.sv
module tpx_frame_gen
    import tpx_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_t              job,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] buf_addr,
    input  byte_t             buf_rdata,
    output logic              tx_valid,
    output byte_t             tx_byte,
    output logic              tx_last,
    output logic              done
);
    localparam int POS_W = BYTE_W + 1;

    logic             run_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] len_ext, crc_lo_pos, last_pos;
    logic [15:0]      crc;
    byte_t            cur_byte;
    logic             crc_step;

    assign len_ext    = {1'b0, job.len};
    assign crc_lo_pos = len_ext + POS_W'(2);
    assign last_pos   = len_ext + POS_W'(3);
    assign done       = run_q && (pos_q == last_pos);
    assign crc_step   = run_q && (pos_q < crc_lo_pos);
    assign buf_addr   = base + ADDR_W'(pos_q) - ADDR_W'(2);

    always_comb begin
        if (pos_q == '0) begin
            cur_byte = job.dest;
        end else if (pos_q == POS_W'(1)) begin
            cur_byte = job.len;
        end else if (pos_q == crc_lo_pos) begin
            cur_byte = crc[7:0];
        end else if (pos_q == last_pos) begin
            cur_byte = crc[15:8];
        end else begin
            cur_byte = buf_rdata;
        end
    end

    tpx_crc16 u_crc (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .step (crc_step),
        .din  (cur_byte),
        .crc  (crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            pos_q    <= '0;
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= run_q;
            tx_last  <= done;
            if (run_q) begin
                tx_byte <= cur_byte;
            end
            if (start) begin
                run_q <= 1'b1;
                pos_q <= '0;
            end else if (run_q) begin
                if (done) begin
                    run_q <= 1'b0;
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end
    end

    // R4: bytes only leave while a frame is running
    p_byte_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(run_q));
    // R5: the flagged final byte closes the stream
    p_last_closes_r5: assert property (@(posedge clk) disable iff (rst)
        tx_last |=> !tx_valid);
endmodule

// File: rtl/tpx_seq_top.sv
module tpx_seq_top
    import tpx_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int REPLY_TMO = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_enable,
    input  logic              tx_disable,
    input  logic [7:0]        dest_in,
    input  logic [7:0]        len_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [7:0]        next_id,
    input  logic              token_in,
    input  logic              rx_ack,
    input  logic              rx_nak,
    input  logic [1:0]        irq_mask,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_rdata,
    output logic              req_valid,
    output logic              req_kind,
    output logic [7:0]        req_dst,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_last,
    output logic              st_avail,
    output logic              st_delivered,
    output logic              irq
);
    localparam int NSTAT = 2;

    seq_state_e        st_q;
    job_t              job_q;
    logic [ADDR_W-1:0] base_q;
    logic              pending_q, cancel_q;
    status_t           stat_q;
    logic              start, gen_done, waiting, expire;
    logic [NSTAT-1:0]  stat_vec, irq_bits;

    assign waiting = (st_q == S_WENQ) || (st_q == S_WACK);
    assign start   = (st_q == S_WENQ) && rx_ack;

    tpx_reply_timer #(.LIMIT(REPLY_TMO)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (waiting),
        .expire (expire)
    );

    tpx_frame_gen #(.ADDR_W(ADDR_W)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .job       (job_q),
        .base      (base_q),
        .buf_addr  (buf_addr),
        .buf_rdata (buf_rdata),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_last   (tx_last),
        .done      (gen_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            job_q     <= '0;
            base_q    <= '0;
            pending_q <= 1'b0;
            cancel_q  <= 1'b0;
            stat_q    <= '{delivered: 1'b0, avail: 1'b1};
            req_valid <= 1'b0;
            req_kind  <= REQ_TOKEN;
            req_dst   <= '0;
        end else begin
            req_valid <= 1'b0;
            if (tx_enable && !pending_q) begin
                pending_q        <= 1'b1;
                cancel_q         <= 1'b0;
                job_q            <= '{dest: dest_in, len: len_in};
                base_q           <= base_in;
                stat_q.avail     <= 1'b0;
                stat_q.delivered <= 1'b0;
            end
            if (tx_disable && pending_q) begin
                cancel_q <= 1'b1;
            end
            case (st_q)
                S_IDLE: begin
                    if (token_in) begin
                        req_valid <= 1'b1;
                        if (pending_q && !cancel_q) begin
                            req_kind <= REQ_ENQ;
                            req_dst  <= job_q.dest;
                            st_q     <= S_WENQ;
                        end else begin
                            req_kind <= REQ_TOKEN;
                            req_dst  <= next_id;
                            if (pending_q) begin
                                pending_q    <= 1'b0;
                                cancel_q     <= 1'b0;
                                stat_q.avail <= 1'b1;
                            end
                        end
                    end
                end
                S_WENQ: begin
                    if (rx_ack) begin
                        st_q <= S_SEND;
                    end else if (rx_nak || expire) begin
                        req_valid <= 1'b1;
                        req_kind  <= REQ_TOKEN;
                        req_dst   <= next_id;
                        st_q      <= S_IDLE;
                    end
                end
                S_SEND: begin
                    if (gen_done) begin
                        st_q <= S_WACK;
                    end
                end
                S_WACK: begin
                    if (rx_ack || expire) begin
                        stat_q.delivered <= rx_ack;
                        stat_q.avail     <= 1'b1;
                        pending_q        <= 1'b0;
                        cancel_q         <= 1'b0;
                        req_valid        <= 1'b1;
                        req_kind         <= REQ_TOKEN;
                        req_dst          <= next_id;
                        st_q             <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign stat_vec = {stat_q.delivered, stat_q.avail};

    for (genvar g = 0; g < NSTAT; g++) begin : g_irq
        assign irq_bits[g] = stat_vec[g] & irq_mask[g];
    end

    assign irq          = |irq_bits;
    assign st_avail     = stat_q.avail;
    assign st_delivered = stat_q.delivered;

    // R2: an armed attempt keeps the transmitter busy
    p_busy_while_armed_r2: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> !st_avail);
    // R3: an enquiry is always followed by waiting for its reply
    p_enq_then_wait_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == REQ_ENQ) |-> (st_q == S_WENQ));
    // R6: a refused enquiry passes the token and keeps the attempt
    p_nak_keeps_job_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WENQ && rx_nak && !rx_ack) |=>
            (pending_q && !st_avail && req_valid && req_kind == REQ_TOKEN));
    // R7: acknowledged data marks delivery
    p_ack_delivers_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WACK && rx_ack) |=> (st_delivered && st_avail && !pending_q));
endmodule

// File: tb/tpx_seq_top_tb_top.sv
module tpx_seq_top_tb_top;
    localparam int ADDR_W = 11;
    localparam int TMO    = 64;
    localparam int DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_enable = 0, tx_disable = 0, token_in = 0, rx_ack = 0, rx_nak = 0;
    logic [7:0] dest_in = 0, len_in = 0, next_id = 8'h21;
    logic [ADDR_W-1:0] base_in = 0;
    logic [1:0] irq_mask = 2'b00;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0] buf_rdata;
    logic req_valid, req_kind, tx_valid, tx_last, st_avail, st_delivered, irq;
    logic [7:0] req_dst, tx_byte;
    logic [7:0] mem [DEPTH];

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    assign buf_rdata = mem[buf_addr];

    tpx_seq_top #(.ADDR_W(ADDR_W), .REPLY_TMO(TMO)) dut_i (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .tx_disable(tx_disable),
        .dest_in(dest_in), .len_in(len_in), .base_in(base_in), .next_id(next_id),
        .token_in(token_in), .rx_ack(rx_ack), .rx_nak(rx_nak), .irq_mask(irq_mask),
        .buf_addr(buf_addr), .buf_rdata(buf_rdata), .req_valid(req_valid),
        .req_kind(req_kind), .req_dst(req_dst), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last), .st_avail(st_avail),
        .st_delivered(st_delivered), .irq(irq)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_token;
        token_in = 1; tick(); token_in = 0;
    endtask
    task automatic pulse_ack;
        rx_ack = 1; tick(); rx_ack = 0;
    endtask
    task automatic pulse_nak;
        rx_nak = 1; tick(); rx_nak = 0;
    endtask

    task automatic do_enable(input logic [7:0] d, input logic [7:0] l, input int b);
        dest_in = d; len_in = l; base_in = ADDR_W'(b); tx_enable = 1;
        tick(); tx_enable = 0;
    endtask

    function automatic logic [15:0] crc_model(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb = r[0] ^ b[k];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic check_req(input logic kind, input logic [7:0] dst, input string tag);
        chk(req_valid == 1'b1, {tag, " req_valid"}, req_valid, 1);
        chk(req_kind == kind, {tag, " req_kind"}, req_kind, kind);
        chk(req_dst == dst, {tag, " req_dst"}, req_dst, dst);
    endtask

    // after the enquiry ACK: check the whole frame (R4, R5)
    task automatic check_frame(input logic [7:0] d, input logic [7:0] l, input int b);
        logic [15:0] c = 16'h0000;
        logic [7:0] exp_b;
        pulse_ack();
        chk(tx_valid == 1'b0, "R4 no byte in ack cycle", tx_valid, 0);
        for (int i = 0; i < l + 4; i++) begin
            tick();
            if (i == 0) exp_b = d;
            else if (i == 1) exp_b = l;
            else if (i < l + 2) exp_b = mem[(b + i - 2) % DEPTH];
            else if (i == l + 2) exp_b = c[7:0];
            else exp_b = c[15:8];
            if (i < l + 2) c = crc_model(c, exp_b);
            chk(tx_valid == 1'b1, "R4 tx_valid in frame", tx_valid, 1);
            chk(tx_byte == exp_b, (i >= l + 2) ? "R5 crc byte" : "R4 frame byte", tx_byte, exp_b);
            chk(tx_last == (i == l + 3), "R5 tx_last", tx_last, (i == l + 3));
        end
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!req_valid && n < 4 * TMO) begin
            tick();
            n++;
        end
    endtask

    task automatic t_reset;
        irq_mask = 2'b00;
        chk(st_avail == 1, "R1 st_avail", st_avail, 1);
        chk(st_delivered == 0, "R1 st_delivered", st_delivered, 0);
        chk(req_valid == 0, "R1 req_valid", req_valid, 0);
        chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
        chk(irq == 0, "R10 irq masked", irq, 0);
    endtask

    task automatic t_idle_pass;
        pulse_token();
        check_req(1'b0, 8'h21, "R9 idle token");
        tick();
        chk(req_valid == 0, "R9 single-cycle request", req_valid, 1'b0);
    endtask

    task automatic t_deliver;
        do_enable(8'h5A, 8'd5, 100);
        chk(st_avail == 0, "R2 avail cleared", st_avail, 0);
        pulse_token();
        check_req(1'b1, 8'h5A, "R3 enquiry");
        chk(tx_valid == 0, "R3 no data before reply", tx_valid, 0);
        check_frame(8'h5A, 8'd5, 100);
        pulse_ack();
        chk(st_delivered == 1, "R7 delivered", st_delivered, 1);
        chk(st_avail == 1, "R7 avail", st_avail, 1);
        check_req(1'b0, 8'h21, "R7 token pass");
    endtask

    task automatic t_irq;
        irq_mask = 2'b01; #1;
        chk(irq == 1, "R10 avail masked in", irq, 1);
        irq_mask = 2'b10; #1;
        chk(irq == 1, "R10 delivered masked in", irq, 1);
        irq_mask = 2'b00; #1;
        chk(irq == 0, "R10 all masked", irq, 0);
        do_enable(8'h44, 8'd1, 0);
        irq_mask = 2'b11; #1;
        chk(irq == 0, "R10 no status true", irq, 0);
        chk(st_delivered == 0, "R2 delivered cleared", st_delivered, 0);
        tx_disable = 1; tick(); tx_disable = 0;
        pulse_token();
        check_req(1'b0, 8'h21, "R11 cancel cleanup");
        chk(irq == 1, "R10 avail back", irq, 1);
        irq_mask = 2'b00;
    endtask

    task automatic t_nak_retry;
        int n;
        do_enable(8'h33, 8'd3, DEPTH - 2);
        pulse_token();
        check_req(1'b1, 8'h33, "R3 enquiry 2");
        pulse_nak();
        check_req(1'b0, 8'h21, "R6 nak token pass");
        chk(st_avail == 0, "R6 still pending", st_avail, 0);
        chk(tx_valid == 0, "R6 no data after nak", tx_valid, 0);
        pulse_token();
        check_req(1'b1, 8'h33, "R6 retry enquiry");
        tick();
        wait_req(n);
        chk(n == TMO - 1, "R6 enquiry timeout cycles", n + 1, TMO);
        check_req(1'b0, 8'h21, "R6 timeout token pass");
        chk(st_avail == 0, "R6 pending after timeout", st_avail, 0);
        pulse_token();
        check_req(1'b1, 8'h33, "R6 second retry");
        check_frame(8'h33, 8'd3, DEPTH - 2);
        wait_req(n);
        chk(n == TMO, "R8 ack window cycles", n, TMO);
        check_req(1'b0, 8'h21, "R8 token pass");
        chk(st_avail == 1, "R8 avail", st_avail, 1);
        chk(st_delivered == 0, "R8 not delivered", st_delivered, 0);
    endtask

    task automatic t_ignore_and_cancel;
        do_enable(8'h11, 8'd1, 0);
        do_enable(8'h22, 8'd2, 0);
        pulse_token();
        check_req(1'b1, 8'h11, "R12 second enable ignored");
        pulse_nak();
        tx_disable = 1; tick(); tx_disable = 0;
        pulse_token();
        check_req(1'b0, 8'h21, "R11 cancelled at token");
        chk(st_avail == 1, "R11 avail", st_avail, 1);
        chk(st_delivered == 0, "R11 not delivered", st_delivered, 0);
        pulse_token();
        check_req(1'b0, 8'h21, "R11 nothing armed after cancel");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 37 + 11);
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tick();
        t_reset();
        t_idle_pass();
        t_deliver();
        t_irq();
        t_nak_retry();
        t_ignore_and_cancel();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule